// File: doc/BRIEF.md
# Cross-Processor Software Interrupt Mailbox

This block lets three processors signal each other with software interrupts: two general-purpose cores and one signal-processing core. Each processor owns a lane of four interrupt bits. When a processor writes a 1 into one of its own bits, that bit becomes pending. Every pending bit is presented as a level interrupt to all three processors at once, the sender included.

A processor that services an interrupt removes it by writing a 1 to the same bit position at a second address, one word above the status word. The register bus is single-cycle: an address, a write strobe, write data, a requester identifier naming the processor that drives the access, and combinational read data.

The 32-bit bus word is sparse. Lane s occupies word bits 8*s to 8*s+3, so lane 0 uses bits 0-3, lane 1 uses bits 8-11 and lane 2 uses bits 16-19. No other position holds state. The interrupt outputs are packed into a compact 12-bit vector: bit 4*s+b of each output vector is word bit 8*s+b.

Top module: `ipi_mailbox`

## Requirements
- R1: While reset is asserted and after it is released, no bit is pending, all three interrupt vectors are 0, and reads of byte offsets 0x0 and 0x4 return 0.
- R2: A write to offset 0x0 with requester ID s (0, 1 or 2) sets every bit b of lane s for which write-data bit 8*s+b is 1. A 0 in those positions leaves the bit unchanged. The result is visible on the outputs from the clock edge that takes the write.
- R3: A write to offset 0x0 changes no bit outside the requester's own lane, and a write to offset 0x0 with requester ID 3 changes nothing.
- R4: A write to offset 0x4 clears every pending bit whose word position holds a 1, in any lane and from any requester. A 0 leaves the bit unchanged.
- R5: Word positions outside the three lanes always read 0, and writing 1 to them has no effect.
- R6: The three interrupt vectors are identical level signals that equal the pending bits, with output bit 4*s+b carrying lane s, bit b.
- R7: Reads at offset 0x4 return the same word as reads at offset 0x0. Any other offset reads 0, and writes to it change nothing.
- R8: A read in the same cycle as a write returns the word as it was before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 6 | Byte address of the access |
| bus_we_i | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata_i | input | 32 | Write data word |
| bus_id_i | input | 2 | Requester: 0 and 1 are the cores, 2 is the signal-processing core, 3 is no owner |
| bus_rdata_o | output | 32 | Combinational read data for bus_addr_i |
| irq_core0_o | output | 12 | Pending interrupts toward core 0 |
| irq_core1_o | output | 12 | Pending interrupts toward core 1 |
| irq_dsp_o | output | 12 | Pending interrupts toward the signal-processing core |

## Verification
A read and a write share the same address and can fall in the same cycle. In that cycle the read must show the word from before the write, and the new value must appear only after the clock edge. Every write in the sweep is therefore checked twice: the read data while the strobe is held against the model's old value, and then the outputs and both read offsets against the updated model. The sweep covers every 4-bit pattern from every requester ID, with unrelated bits of the word filled with junk. A clear follows each set with a different pattern, so that set and clear leave overlapping, partly changed lanes.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int NUM_SRC     = 3;
    localparam int LANE_BITS   = 4;
    localparam int LANE_STRIDE = 8;
    localparam int DATA_W      = 32;
    localparam int ID_W        = 2;
    localparam int IRQ_W       = NUM_SRC * LANE_BITS;

    typedef struct packed {
        logic [IRQ_W-1:0] pending;
    } pend_state_t;
endpackage

// File: rtl/ipi_lane_map.sv
// Converts between the sparse bus word and the compact interrupt vector.
module ipi_lane_map
    import ipi_pkg::*;
(
    input  logic [DATA_W-1:0] word_i,
    output logic [IRQ_W-1:0]  compact_o,
    input  logic [IRQ_W-1:0]  compact_i,
    output logic [DATA_W-1:0] word_o
);
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_lane
        for (genvar b = 0; b < LANE_BITS; b++) begin : g_bit
            assign compact_o[s*LANE_BITS+b] = word_i[s*LANE_STRIDE+b];
        end
    end

    always_comb begin
        word_o = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            for (int b = 0; b < LANE_BITS; b++) begin
                word_o[s*LANE_STRIDE+b] = compact_i[s*LANE_BITS+b];
            end
        end
    end
endmodule

// File: rtl/ipi_write_decode.sv
// Turns one bus write into per-bit set and clear requests.
module ipi_write_decode
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
    parameter logic [ADDR_W-1:0] CLEAR_ADDR  = ADDR_W'(4)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [ID_W-1:0]   id_i,
    input  logic [IRQ_W-1:0]  wbits_i,
    output logic [IRQ_W-1:0]  set_o,
    output logic [IRQ_W-1:0]  clr_o
);
    logic [IRQ_W-1:0] own_mask;
    logic             hit_status;
    logic             hit_clear;

    always_comb begin
        own_mask = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (id_i == ID_W'(s)) begin
                own_mask[s*LANE_BITS +: LANE_BITS] = '1;
            end
        end
        hit_status = we_i && (addr_i == STATUS_ADDR);
        hit_clear  = we_i && (addr_i == CLEAR_ADDR);
        set_o      = hit_status ? (wbits_i & own_mask) : '0;
        clr_o      = hit_clear  ? wbits_i : '0;
    end
endmodule

// File: rtl/ipi_pending_reg.sv
// Pending bits; a set beats a clear of the same bit in one cycle.
module ipi_pending_reg
    import ipi_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [IRQ_W-1:0] set_i,
    input  logic [IRQ_W-1:0] clr_i,
    output logic [IRQ_W-1:0] pend_o
);
    pend_state_t st_d;
    pend_state_t st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pending = (st_q.pending & ~clr_i) | set_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pending;
endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
    parameter logic [ADDR_W-1:0] CLEAR_ADDR  = ADDR_W'(4)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [31:0]       bus_wdata_i,
    input  logic [1:0]        bus_id_i,
    output logic [31:0]       bus_rdata_o,
    output logic [11:0]       irq_core0_o,
    output logic [11:0]       irq_core1_o,
    output logic [11:0]       irq_dsp_o
);
    logic [IRQ_W-1:0]  wbits;
    logic [IRQ_W-1:0]  set_bits;
    logic [IRQ_W-1:0]  clr_bits;
    logic [IRQ_W-1:0]  pending;
    logic [DATA_W-1:0] pend_word;

    ipi_lane_map u_map (
        .word_i    (bus_wdata_i),
        .compact_o (wbits),
        .compact_i (pending),
        .word_o    (pend_word)
    );

    ipi_write_decode #(
        .ADDR_W      (ADDR_W),
        .STATUS_ADDR (STATUS_ADDR),
        .CLEAR_ADDR  (CLEAR_ADDR)
    ) u_dec (
        .addr_i  (bus_addr_i),
        .we_i    (bus_we_i),
        .id_i    (bus_id_i),
        .wbits_i (wbits),
        .set_o   (set_bits),
        .clr_o   (clr_bits)
    );

    ipi_pending_reg u_pend (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (set_bits),
        .clr_i  (clr_bits),
        .pend_o (pending)
    );

    assign bus_rdata_o = ((bus_addr_i == STATUS_ADDR) || (bus_addr_i == CLEAR_ADDR))
                         ? pend_word : '0;
    assign irq_core0_o = pending;
    assign irq_core1_o = pending;
    assign irq_dsp_o   = pending;
endmodule

// File: rtl/ipi_mailbox_chk.sv
module ipi_mailbox_chk
    import ipi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter logic [ADDR_W-1:0] STATUS_ADDR = '0,
    parameter logic [ADDR_W-1:0] CLEAR_ADDR  = ADDR_W'(4)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic [31:0]       bus_wdata_i,
    input logic [1:0]        bus_id_i,
    input logic [31:0]       bus_rdata_o,
    input logic [11:0]       irq_core0_o,
    input logic [11:0]       irq_core1_o,
    input logic [11:0]       irq_dsp_o
);
    function automatic logic [IRQ_W-1:0] pick(input logic [DATA_W-1:0] w);
        logic [IRQ_W-1:0] r;
        for (int k = 0; k < IRQ_W; k++) r[k] = w[(k / LANE_BITS) * LANE_STRIDE + (k % LANE_BITS)];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] spread(input logic [IRQ_W-1:0] c);
        logic [DATA_W-1:0] r;
        r = '0;
        for (int k = 0; k < IRQ_W; k++) r[(k / LANE_BITS) * LANE_STRIDE + (k % LANE_BITS)] = c[k];
        return r;
    endfunction

    function automatic logic [IRQ_W-1:0] lane_of(input logic [ID_W-1:0] id);
        logic [IRQ_W-1:0] r;
        r = '0;
        for (int k = 0; k < IRQ_W; k++) r[k] = (int'(id) == k / LANE_BITS);
        return r;
    endfunction

    logic wr_status;
    logic wr_clear;
    logic wr_any;
    assign wr_status = bus_we_i && (bus_addr_i == STATUS_ADDR);
    assign wr_clear  = bus_we_i && (bus_addr_i == CLEAR_ADDR);
    assign wr_any    = wr_status || wr_clear;

    AST_DEST_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_core0_o == irq_core1_o) && (irq_core1_o == irq_dsp_o)); // R6

    AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_status |=> ((irq_core0_o & $past(pick(bus_wdata_i) & lane_of(bus_id_i)))
                       == $past(pick(bus_wdata_i) & lane_of(bus_id_i)))); // R2

    AST_FOREIGN_LANE_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_status |=> (((irq_core0_o ^ $past(irq_core0_o)) & ~$past(lane_of(bus_id_i))) == '0)); // R3

    AST_CLEAR_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_clear |=> ((irq_core0_o & ~$past(irq_core0_o)) == '0)); // R4

    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_clear |=> ((irq_core0_o & $past(pick(bus_wdata_i))) == '0)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_any |=> $stable(irq_core0_o)); // R7

    AST_READ_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((bus_addr_i == STATUS_ADDR) || (bus_addr_i == CLEAR_ADDR))
        |-> (bus_rdata_o == spread(irq_dsp_o))); // R8

    AST_INVALID_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rdata_o & ~spread('1)) == '0); // R5
endmodule

bind ipi_mailbox ipi_mailbox_chk #(
    .ADDR_W      (ADDR_W),
    .STATUS_ADDR (STATUS_ADDR),
    .CLEAR_ADDR  (CLEAR_ADDR)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_id_i    (bus_id_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_core0_o (irq_core0_o),
    .irq_core1_o (irq_core1_o),
    .irq_dsp_o   (irq_dsp_o)
);

// File: tb/ipi_mailbox_tb_top.sv
module ipi_mailbox_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [1:0]  id = '0;
    logic [31:0] rdata;
    logic [11:0] irq0, irq1, irq2;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [11:0] model = '0;

    always #4 clk = ~clk;

    ipi_mailbox dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_addr_i  (addr),
        .bus_we_i    (we),
        .bus_wdata_i (wdata),
        .bus_id_i    (id),
        .bus_rdata_o (rdata),
        .irq_core0_o (irq0),
        .irq_core1_o (irq1),
        .irq_dsp_o   (irq2)
    );

    // Word bit 8*s+b holds lane s bit b; outputs carry it at 4*s+b.
    function automatic logic [31:0] to_word(input logic [11:0] c);
        logic [31:0] w = '0;
        for (int s = 0; s < 3; s++)
            for (int b = 0; b < 4; b++) w[8*s+b] = c[4*s+b];
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_state(input string tag);
        check({tag, " irq core0"}, {20'd0, irq0}, {20'd0, model});
        check({tag, " R6 irq core1"}, {20'd0, irq1}, {20'd0, model});
        check({tag, " R6 irq dsp"}, {20'd0, irq2}, {20'd0, model});
        addr = 6'h0; #1;
        check({tag, " R5 read status"}, rdata, to_word(model));
        addr = 6'h4; #1;
        check({tag, " R7 read clear"}, rdata, to_word(model));
        addr = 6'h8; #1;
        check({tag, " R7 read other"}, rdata, 32'h0);
    endtask

    task automatic bus_write(input string tag, input logic [5:0] a,
                             input logic [1:0] rid, input logic [31:0] d);
        @(negedge clk);
        addr = a; id = rid; wdata = d; we = 1'b1;
        #1;
        if (a == 6'h0 || a == 6'h4) check({tag, " R8 read during write"}, rdata, to_word(model));
        else                        check({tag, " R7 read during write"}, rdata, 32'h0);
        if (a == 6'h0 && rid != 2'd3) begin
            for (int b = 0; b < 4; b++)
                if (d[8*rid+b]) model[4*rid+b] = 1'b1;
        end else if (a == 6'h4) begin
            for (int s = 0; s < 3; s++)
                for (int b = 0; b < 4; b++)
                    if (d[8*s+b]) model[4*s+b] = 1'b0;
        end
        @(negedge clk);
        we = 1'b0; wdata = '0;
        #1;
        check_state(tag);
    endtask

    initial begin
        #1;
        check("R1 irq in reset", {20'd0, irq0 | irq1 | irq2}, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check_state("R1 after reset");

        for (int r = 0; r < 4; r++) begin
            for (int p = 0; p < 16; p++) begin
                logic [3:0] q = 4'(p);
                bus_write(r == 3 ? "R3 set no owner" : "R2 R3 set",
                          6'h0, 2'(r), {4'hC, q, 4'h9, q, 4'h3, q, 4'hE, q});
                bus_write("R4 clear", 6'h4, 2'(r),
                          {4'h7, q ^ 4'h5, 4'hA, q ^ 4'h3, 4'h6, q ^ 4'hC, 4'hB, q ^ 4'h9});
            end
        end
        bus_write("R3 R5 set all ones id0", 6'h0, 2'd0, 32'hFFFF_FFFF);
        bus_write("R2 set all ones id1", 6'h0, 2'd1, 32'hFFFF_FFFF);
        bus_write("R2 set all ones id2", 6'h0, 2'd2, 32'hFFFF_FFFF);
        bus_write("R7 write other addr", 6'h8, 2'd0, 32'h0);
        bus_write("R7 clear via other addr", 6'h8, 2'd1, 32'hFFFF_FFFF);
        bus_write("R4 clear zeros", 6'h4, 2'd3, 32'h0);
        bus_write("R5 clear invalid only", 6'h4, 2'd0, 32'hFFF0_F0F0);
        bus_write("R4 clear all", 6'h4, 2'd3, 32'hFFFF_FFFF);
        bus_write("R2 set after clear", 6'h0, 2'd2, 32'h000A_0000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule